// File: doc/BRIEF.md
# Three-Phase Complementary Gate Timer

This block drives the six gate signals of a three-phase half-bridge inverter. One shared counter forms the carrier. A mode input chooses between two shapes. In the symmetric triangle shape the counter rises from zero to the peak and falls back again. In the sawtooth shape it counts upward from zero and restarts. Each phase has its own compare value, and the compare decides when that phase's high-side switch is commanded on. The low-side switch is commanded on for the rest of the carrier period. A programmable guard interval holds back the turn-on of either switch after every change of command, so the two switches of a leg are never on together.

A one-cycle sampling strobe marks each point where the counter is at zero. At that point every high-side output is off, so an external converter can sample all three shunt currents together. Period, compares, guard interval and mode come in on plain input ports that act as shadow values. The block copies them into its working registers only at the edge where the counter returns to zero, so a carrier period never mixes old and new settings. Dropping the enable or the reset stops the counter and turns off all six outputs. Switching starts again at the first zero of the counter after enable returns.

Top module: `tri_gate_pwm`

## Requirements
- R1: With the active mode value 1 (triangle), the counter steps 0,1,...,P,P-1,...,1 and repeats, so successive sampling strobes are 2P cycles apart, where P is the active period value.
- R2: With the active mode value 0 (sawtooth), the counter steps 0,1,...,P-1 and wraps to 0, so successive sampling strobes are P cycles apart.
- R3: For phase i, the compare value is taken from duty_i bits [i*CNT_W +: CNT_W]. The high-side command is on while the block runs and the counter is strictly greater than that compare. The low-side command is on while the block runs and the counter is not greater. With a guard of 0 the high output is therefore on for 2(P-C)-1 cycles per triangle period, or P-1-C cycles per sawtooth period, where C is the compare value, and the two outputs of a phase are exact complements.
- R4: An output is on in a cycle only when its command has been on, while running, for that cycle and the D cycles before it, where D is the active guard value. Both outputs of a phase are therefore off for D cycles after every command change, and a command lasting D cycles or fewer never reaches the output.
- R5: adc_trig is high for exactly the cycles in which the block runs and the counter is 0, one cycle at a time. In those cycles gate_hi is all zero.
- R6: period_i, duty_i, dead_i and mode_i are sampled only on the clock edge that brings the counter to 0, or on the edge that starts the block. A change at any other time has no effect on the outputs until that edge.
- R7: While rst_n is low, and from the cycle after enable is sampled low, all gate outputs and adc_trig are 0 and the counter is cleared. The cycle after enable is first sampled high is a counter zero, with adc_trig high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low stops the counter and turns off all gates |
| mode_i | input | 1 | Shadow carrier mode: 1 triangle, 0 sawtooth |
| period_i | input | CNT_W | Shadow peak count P (at least 2) |
| duty_i | input | PHASES*CNT_W | Shadow compare values, phase i at bits [i*CNT_W +: CNT_W] |
| dead_i | input | DT_W | Shadow guard interval in clock cycles |
| gate_hi | output | PHASES | High-side gate per phase |
| gate_lo | output | PHASES | Low-side gate per phase |
| adc_trig | output | 1 | One-cycle strobe at each counter zero |

## Verification
The compare value is swept from 0 past the peak on a small carrier, in both modes and for guard values 0 to 3. The measured high-side width per period separates a wrong compare direction, an off-by-one at the peak or wrap, and a guard that is applied once per pulse rather than per edge. Every cycle, each gate and the strobe are compared with an arithmetic model of the counter and the run-length rule, which exposes asymmetries between the rising and falling halves of the triangle. Writes of period and compare in the middle of a period must leave that period untouched and take effect in the next one, which separates shadowed loading from live loading. Disable, re-enable and a reset in mid-run show that the outputs turn off at once and that the restart is aligned to the counter zero.

// File: rtl/gpwm_pkg.sv
package gpwm_pkg;

   typedef enum logic {
      CAR_SAW = 1'b0,
      CAR_TRI = 1'b1
   } carrier_e;

endpackage

// File: rtl/gpwm_carrier.sv
module gpwm_carrier
   import gpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             mode_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             run_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             load_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   carrier_e         mode_act;
   logic [CNT_W-1:0] per_act;
   logic             falling;
   logic [CNT_W:0]   cnt_inc;
   logic             at_top;

   assign cnt_inc = {1'b0, cnt_o} + {{CNT_W{1'b0}}, 1'b1};
   assign at_top  = cnt_inc >= {1'b0, per_act};

   always_comb begin
      if (!enable)
         load_o = 1'b0;
      else if (!run_o)
         load_o = 1'b1;
      else if (mode_act == CAR_TRI)
         load_o = falling && (cnt_o <= ONE);
      else
         load_o = at_top;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o    <= 1'b0;
         cnt_o    <= '0;
         falling  <= 1'b0;
         per_act  <= '0;
         mode_act <= CAR_SAW;
      end else begin
         if (load_o) begin
            per_act  <= period_i;
            mode_act <= carrier_e'(mode_i);
         end
         if (!enable) begin
            run_o   <= 1'b0;
            cnt_o   <= '0;
            falling <= 1'b0;
         end else if (!run_o) begin
            run_o   <= 1'b1;
            cnt_o   <= '0;
            falling <= 1'b0;
         end else if (mode_act == CAR_TRI) begin
            if (!falling) begin
               cnt_o <= cnt_inc[CNT_W-1:0];
               if (at_top)
                  falling <= 1'b1;
            end else if (cnt_o <= ONE) begin
               cnt_o   <= '0;
               falling <= 1'b0;
            end else begin
               cnt_o <= cnt_o - ONE;
            end
         end else begin
            cnt_o <= at_top ? '0 : cnt_inc[CNT_W-1:0];
         end
      end
   end

   // R1: triangle carrier moves by exactly one step each cycle
   a_r1_tri_step : assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && $past(run_o) && mode_act == CAR_TRI && $past(mode_act) == CAR_TRI)
      |-> (cnt_o == $past(cnt_o) + ONE || cnt_o == $past(cnt_o) - ONE));

   // R2: sawtooth carrier either increments or wraps to zero
   a_r2_saw_step : assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && $past(run_o) && mode_act == CAR_SAW)
      |-> (cnt_o == $past(cnt_o) + ONE || cnt_o == '0));

endmodule

// File: rtl/gpwm_deadband.sv
module gpwm_deadband #(
   parameter int DT_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            cmd_hi,
   input  logic [DT_W-1:0] dead,
   output logic            hi_o,
   output logic            lo_o
);

   localparam logic [DT_W-1:0] AGE_MAX = '1;

   logic            last_cmd;
   logic [DT_W-1:0] age;
   logic            held;
   logic            no_guard;

   // last_cmd holds the command of the previous cycle; age counts the
   // cycles it has been steady, minus one. Idle forces a change so that
   // the first running cycle starts a fresh run.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_cmd <= 1'b1;
         age      <= '0;
      end else if (!run) begin
         last_cmd <= 1'b1;
         age      <= '0;
      end else if (cmd_hi != last_cmd) begin
         last_cmd <= cmd_hi;
         age      <= '0;
      end else if (age != AGE_MAX) begin
         age <= age + 1'b1;
      end
   end

   assign no_guard = (dead == '0);
   assign held     = ({1'b0, age} + {{DT_W{1'b0}}, 1'b1}) >= {1'b0, dead};
   assign hi_o     = run &&  cmd_hi && (no_guard || ( last_cmd && held));
   assign lo_o     = run && !cmd_hi && (no_guard || (!last_cmd && held));

   // R4: with a guard, a turn-on never directly follows the partner's on cycle
   a_r4_hi_after_gap : assert property (@(posedge clk) disable iff (!rst_n)
      (dead != '0 && $rose(hi_o)) |-> !$past(lo_o));

   a_r4_lo_after_gap : assert property (@(posedge clk) disable iff (!rst_n)
      (dead != '0 && $rose(lo_o)) |-> !$past(hi_o));

endmodule

// File: rtl/tri_gate_pwm.sv
module tri_gate_pwm
   import gpwm_pkg::*;
#(
   parameter int PHASES = 3,
   parameter int CNT_W  = 16,
   parameter int DT_W   = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    mode_i,
   input  logic [CNT_W-1:0]        period_i,
   input  logic [PHASES*CNT_W-1:0] duty_i,
   input  logic [DT_W-1:0]         dead_i,
   output logic [PHASES-1:0]       gate_hi,
   output logic [PHASES-1:0]       gate_lo,
   output logic                    adc_trig
);

   if (PHASES < 1) begin : g_bad_phases
      $error("tri_gate_pwm: PHASES must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tri_gate_pwm: CNT_W must be at least 2");
   end
   if (DT_W < 1) begin : g_bad_dt
      $error("tri_gate_pwm: DT_W must be at least 1");
   end

   logic             run;
   logic [CNT_W-1:0] cnt;
   logic             load;
   logic [DT_W-1:0]  dead_act;

   gpwm_carrier #(
      .CNT_W (CNT_W)
   ) u_carrier (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .mode_i   (mode_i),
      .period_i (period_i),
      .run_o    (run),
      .cnt_o    (cnt),
      .load_o   (load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dead_act <= '0;
      else if (load)
         dead_act <= dead_i;
   end

   for (genvar g = 0; g < PHASES; g++) begin : g_phase
      logic [CNT_W-1:0] cmp_act;
      logic             cmd_hi;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_act <= '0;
         else if (load)
            cmp_act <= duty_i[g*CNT_W +: CNT_W];
      end

      assign cmd_hi = run && (cnt > cmp_act);

      gpwm_deadband #(
         .DT_W (DT_W)
      ) u_guard (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run),
         .cmd_hi (cmd_hi),
         .dead   (dead_act),
         .hi_o   (gate_hi[g]),
         .lo_o   (gate_lo[g])
      );
   end

   assign adc_trig = run && (cnt == '0);

   a_r5_valley_hi_off : assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |-> (gate_hi == '0));

   a_r5_single_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |=> !adc_trig);

   a_r7_disable_off : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (gate_hi == '0 && gate_lo == '0 && !adc_trig));

endmodule

// File: tb/sim_tri_gate_pwm.sv
module sim_tri_gate_pwm;

   localparam int PH = 3;
   localparam int CW = 8;
   localparam int DW = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             enable;
   logic             mode;
   logic [CW-1:0]    period;
   logic [PH*CW-1:0] duty;
   logic [DW-1:0]    dead;
   logic [PH-1:0]    gate_hi;
   logic [PH-1:0]    gate_lo;
   logic             adc_trig;

   int n_chk = 0;
   int n_err = 0;

   // arithmetic model state
   int m_run, m_cnt, m_dn, m_P, m_mode, m_D;
   int m_cmp [PH];
   int rl_h  [PH];
   int rl_l  [PH];

   always #10 clk = ~clk;

   tri_gate_pwm #(
      .PHASES (PH),
      .CNT_W  (CW),
      .DT_W   (DW)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .mode_i   (mode),
      .period_i (period),
      .duty_i   (duty),
      .dead_i   (dead),
      .gate_hi  (gate_hi),
      .gate_lo  (gate_lo),
      .adc_trig (adc_trig)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_duty(input int a, input int b, input int c);
      duty = {CW'(c), CW'(b), CW'(a)};
   endtask

   // compare this cycle against the model, advance the model, move to next cycle
   task automatic cycle();
      int ea;
      bit ld;
      if (!rst_n) begin
         m_run = 0; m_cnt = 0; m_dn = 0;
         for (int i = 0; i < PH; i++) begin rl_h[i] = 0; rl_l[i] = 0; end
      end
      for (int i = 0; i < PH; i++) begin
         bit above;
         bit below;
         int eh;
         int el;
         above = (m_run != 0) && (m_cnt > m_cmp[i]);
         below = (m_run != 0) && !(m_cnt > m_cmp[i]);
         rl_h[i] = above ? rl_h[i] + 1 : 0;
         rl_l[i] = below ? rl_l[i] + 1 : 0;
         eh = (rl_h[i] >= m_D + 1) ? 1 : 0;
         el = (rl_l[i] >= m_D + 1) ? 1 : 0;
         chk(int'(gate_hi[i]) == eh, "R4 gate_hi vs model", int'(gate_hi[i]), eh);
         chk(int'(gate_lo[i]) == el, "R4 gate_lo vs model", int'(gate_lo[i]), el);
      end
      ea = (m_run != 0 && m_cnt == 0) ? 1 : 0;
      chk(int'(adc_trig) == ea, "R5 adc_trig vs model", int'(adc_trig), ea);
      if (rst_n) begin
         if (!enable) begin
            m_run = 0; m_cnt = 0; m_dn = 0;
         end else begin
            ld = (m_run == 0) ||
                 (m_mode != 0 ? (m_dn != 0 && m_cnt == 1) : (m_cnt == m_P - 1));
            if (m_run == 0) begin
               m_run = 1; m_cnt = 0; m_dn = 0;
            end else if (m_mode != 0) begin
               if (m_dn == 0) begin
                  m_cnt++;
                  if (m_cnt == m_P) m_dn = 1;
               end else begin
                  m_cnt--;
                  if (m_cnt == 0) m_dn = 0;
               end
            end else begin
               m_cnt = (m_cnt == m_P - 1) ? 0 : m_cnt + 1;
            end
            if (ld) begin
               m_P = int'(period); m_mode = int'(mode); m_D = int'(dead);
               for (int i = 0; i < PH; i++) m_cmp[i] = int'(duty[i*CW +: CW]);
            end
         end
      end
      @(negedge clk);
   endtask

   task automatic wait_adc();
      while (!adc_trig) cycle();
   endtask

   // count phase-0 high cycles over one carrier period starting at a strobe
   task automatic window(output int hc);
      int plen;
      plen = (m_mode != 0) ? 2 * m_P : m_P;
      hc = 0;
      repeat (plen) begin
         hc += int'(gate_hi[0]);
         cycle();
      end
      chk(adc_trig == 1'b1, (m_mode != 0) ? "R1 strobe spacing 2P" : "R2 strobe spacing P",
          int'(adc_trig), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int hc;
      int len;
      int exp;
      m_run = 0; m_cnt = 0; m_dn = 0; m_P = 0; m_mode = 0; m_D = 0;
      for (int i = 0; i < PH; i++) begin m_cmp[i] = 0; rl_h[i] = 0; rl_l[i] = 0; end
      rst_n = 1'b0; enable = 1'b0; mode = 1'b1; period = 8'd10; dead = 4'd2;
      set_duty(2, 5, 8);
      @(negedge clk);
      repeat (3) cycle();
      chk(gate_hi == '0 && gate_lo == '0 && !adc_trig, "R7 reset state",
          int'({gate_hi, gate_lo, adc_trig}), 0);

      // start: the first running cycle is a counter zero
      rst_n = 1'b1; enable = 1'b1;
      cycle();
      chk(adc_trig == 1'b1, "R7 restart at zero", int'(adc_trig), 1);
      chk(gate_hi == '0, "R5 high side off at zero", int'(gate_hi), 0);
      repeat (45) cycle();
      wait_adc();
      window(hc);
      chk(hc == 2 * (10 - 2) - 1 - 2, "R4 triangle width with guard 2", hc, 13);

      // sweep: both modes, guard 0..3, compare 0..P
      for (int md = 1; md >= 0; md--) begin
         for (int d = 0; d < 4; d++) begin
            for (int c = 0; c <= 6; c++) begin
               mode = md[0]; period = 8'd6; dead = DW'(d);
               set_duty(c, 6 - c, c / 2);
               cycle();
               wait_adc();
               if (d == 0)
                  chk(gate_lo == '1, "R3 all low sides on at zero with no guard",
                      int'(gate_lo), 7);
               window(hc);
               if (md == 1) len = (c < 6) ? 2 * (6 - c) - 1 : 0;
               else         len = (c < 5) ? 5 - c : 0;
               exp = (len > d) ? len - d : 0;
               chk(hc == exp, "R3 high width per period (R4 trimmed)", hc, exp);
            end
         end
      end

      // R6: writes in mid-period wait for the next zero
      mode = 1'b1; period = 8'd10; dead = 4'd0;
      set_duty(2, 5, 8);
      cycle();
      wait_adc();
      repeat (3) cycle();
      set_duty(7, 5, 8);
      period = 8'd12;
      hc = 0;
      repeat (17) begin
         hc += int'(gate_hi[0]);
         cycle();
      end
      chk(adc_trig == 1'b1, "R6 old period kept until zero", int'(adc_trig), 1);
      chk(hc == 15, "R6 old compare kept until zero", hc, 15);
      window(hc);
      chk(hc == 9, "R6 new compare after zero", hc, 9);

      // R7: disable mid-run and restart
      repeat (7) cycle();
      enable = 1'b0;
      cycle();
      chk(gate_hi == '0 && gate_lo == '0 && !adc_trig, "R7 disable turns off gates",
          int'({gate_hi, gate_lo, adc_trig}), 0);
      repeat (5) cycle();
      chk(gate_hi == '0 && gate_lo == '0, "R7 stays off while disabled",
          int'({gate_hi, gate_lo}), 0);
      enable = 1'b1;
      cycle();
      chk(adc_trig == 1'b1, "R7 re-enable starts at zero", int'(adc_trig), 1);
      repeat (30) cycle();

      // R7: asynchronous reset in mid-run
      rst_n = 1'b0;
      #1;
      chk(gate_hi == '0 && gate_lo == '0 && !adc_trig, "R7 reset mid-run",
          int'({gate_hi, gate_lo, adc_trig}), 0);
      repeat (2) cycle();
      rst_n = 1'b1;
      repeat (40) cycle();

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule